// File: doc/BRIEF.md
# SONET Transmit Frame Formatter

This block assembles the transmit word stream of an STS-48 frame on a 32-bit datapath. A single-cycle pulse on `frame_start` marks the first word of a frame. From that word on, the block walks through 9 rows of 1080 words each. The first 36 words of every row are transport overhead and the remaining 1044 words are payload. Overhead words come from `oh_in` and payload words come from `pl_in`, with one word offered on every clock. Once the last word of row 8 has gone out, the block idles and drives zeros until the next pulse.

Overhead can be passed through unchanged, or the block can generate part of it itself. A two-bit mode selects one of three behaviours:

- **Pass:** every overhead word comes from `oh_in`.
- **Framing:** the block inserts the framing bytes.
- **Full:** the block inserts the framing bytes and zero-fills all other overhead, except the row-0 trace region.

A frame-synchronous scrambler is XORed onto the outgoing word. A disable input bypasses it. The mode and the disable input are both captured on the frame-start word and hold for the whole frame.

Top module: `sts_tx_formatter`

## Requirements
- R1: The word accepted together with a `frame_start` pulse is row 0, word 0. It is presented one clock later with `tx_sof`, `tx_oh` and `tx_active` all high.
- R2: In every row, words 0 to 35 are flagged overhead (`tx_oh`=1) and words 36 to 1079 are payload taken from `pl_in`. This gives 324 overhead words in a frame.
- R3: A frame is exactly 9 rows, or 9720 words. After that the block drives `tx_active`=0, `tx_oh`=0, `tx_sof`=0 and `tx_data`=0 until the next pulse. The same idle values hold out of reset.
- R4: Mode 0 (pass): every overhead word equals `oh_in`.
- R5: Mode 1 (framing): in row 0, overhead words 0 to 11 are forced to F6F6F6F6 hex and words 12 to 23 are forced to 28282828 hex. All other overhead words equal `oh_in`.
- R6: Modes 2 and 3 (full): framing words are forced as in R5. Row 0 words 24 to 35 equal `oh_in`. Every other overhead word of every row is zero.
- R7: The scrambler uses the x^7+x^6+1 generator with the state update s' = {s[5:0], s[6]^s[5]}. Its output bit is s[6], and the first bit of a word goes to bit 31. The generator is loaded with all ones for row 0 word 36, advances 32 steps per word, and is XORed onto every word except the 36 overhead words of row 0, which are never scrambled.
- R8: When `cfg_scr_off`=1 is captured at frame start, every word of that frame leaves unscrambled.
- R9: `cfg_mode` and `cfg_scr_off` are sampled only on the `frame_start` word. Changes during a frame have no effect on that frame.
- R10: A `frame_start` pulse in the middle of a frame abandons that frame and restarts at row 0, word 0 with a freshly seeded scrambler.
- R11: Each output reflects the input word of the previous clock: one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Marks the first word of a frame |
| cfg_mode | input | 2 | Overhead mode: 0 pass, 1 framing, 2/3 full |
| cfg_scr_off | input | 1 | 1 bypasses the scrambler |
| oh_in | input | 32 | Upstream overhead word |
| pl_in | input | 32 | Upstream payload word |
| tx_data | output | 32 | Formatted, optionally scrambled word |
| tx_oh | output | 1 | Current output word is overhead |
| tx_sof | output | 1 | Current output word is row 0, word 0 |
| tx_active | output | 1 | Output word belongs to a frame |

## Verification
Two situations are hard to reach from the ports. The first is the seed point of the scrambler at row 0, word 36, combined with a frame restart that lands mid-frame while the generator is already running. The bench reaches it by cutting one frame after 3000 words and starting a new one immediately, without idle cycles. The second is configuration churn. The bench redraws `cfg_mode` and `cfg_scr_off` at random on every word that is not a frame start, so each word check also shows that the latched settings hold. Every word of every frame is compared against a bench model that tracks the position and the scrambler sequence.

// File: rtl/sts_fmt_pkg.sv
// Shared constants and helpers for the STS-48 transmit formatter.
// Assumes a 32-bit word datapath with bytes packed MSB first.
package sts_fmt_pkg;

    localparam logic [1:0] MODE_PASS    = 2'd0;
    localparam logic [1:0] MODE_FRAMING = 2'd1;

    localparam logic [7:0] FRAMING_HI = 8'hF6;
    localparam logic [7:0] FRAMING_LO = 8'h28;

    localparam logic [6:0] SCR_SEED = 7'h7F;

    // One step of the x^7+x^6+1 generator; the output bit is s[6].
    function automatic logic [6:0] scr_step(input logic [6:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

endpackage

// File: rtl/sts_fmt_pos.sv
// Row/word position tracker.
// frame_start forces the current word to row 0, word 0.
// After the last word of the last row the tracker goes idle until the next pulse.
module sts_fmt_pos #(
    parameter int ROWS = 9,
    parameter int COLS = 1080,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic          cur_act,
    output logic [RW-1:0] cur_row,
    output logic [CW-1:0] cur_col
);

    logic          act_q;
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;

    // Position of the word on the input this cycle.
    always_comb begin
        cur_act = frame_start | act_q;
        cur_row = frame_start ? '0 : row_q;
        cur_col = frame_start ? '0 : col_q;
    end

    // Advance to the next word; wrap rows; stop after the last row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            row_q <= '0;
            col_q <= '0;
        end else if (cur_act) begin
            if (cur_col == CW'(COLS - 1)) begin
                col_q <= '0;
                if (cur_row == RW'(ROWS - 1)) begin
                    act_q <= 1'b0;
                    row_q <= '0;
                end else begin
                    act_q <= 1'b1;
                    row_q <= cur_row + RW'(1);
                end
            end else begin
                act_q <= 1'b1;
                row_q <= cur_row;
                col_q <= cur_col + CW'(1);
            end
        end
    end

    AST_FRAME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !frame_start && row_q == RW'(ROWS - 1) && col_q == CW'(COLS - 1)) |=> !act_q); // R3
    AST_RESTART_POS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (act_q && row_q == '0 && col_q == CW'(1))); // R10

endmodule

// File: rtl/sts_fmt_ohsel.sv
// Overhead word source selection.
// Picks between the upstream overhead word, the forced framing pattern and zero fill.
// Assumes the overhead region splits into three equal groups: high framing, low framing, trace.
module sts_fmt_ohsel #(
    parameter int W = 32,
    parameter int OH_WORDS = 36,
    parameter int CW = 11,
    localparam int BPW = W / 8,
    localparam int GRP = OH_WORDS / 3
) (
    input  logic [1:0]    mode,
    input  logic          row_is0,
    input  logic [CW-1:0] col,
    input  logic [W-1:0]  oh_in,
    output logic [W-1:0]  oh_word
);
    import sts_fmt_pkg::*;

    logic grp_hi, grp_lo;

    // Classify the overhead word into its group within the row.
    always_comb begin
        grp_hi = col < CW'(GRP);
        grp_lo = !grp_hi && (col < CW'(2 * GRP));
    end

    // Choose the overhead source from the latched mode.
    always_comb begin
        if (mode == MODE_PASS)
            oh_word = oh_in;
        else if (row_is0 && grp_hi)
            oh_word = {BPW{FRAMING_HI}};
        else if (row_is0 && grp_lo)
            oh_word = {BPW{FRAMING_LO}};
        else if (mode == MODE_FRAMING || row_is0)
            oh_word = oh_in;
        else
            oh_word = '0;
    end

endmodule

// File: rtl/sts_fmt_scr.sv
// Frame-synchronous word scrambler keystream.
// Produces W keystream bits per word, MSB first.
// 'seed' loads the all-ones state for the current word; 'en' advances the state.
module sts_fmt_scr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed,
    input  logic         en,
    output logic [W-1:0] ks
);
    import sts_fmt_pkg::*;

    logic [6:0] st_q, nxt;

    // Unroll W generator steps starting from the seed or the held state.
    always_comb begin
        logic [6:0] s;
        s  = seed ? SCR_SEED : st_q;
        ks = '0;
        for (int i = 0; i < W; i++) begin
            ks[W-1-i] = s[6];
            s = scr_step(s);
        end
        nxt = s;
    end

    // Hold the generator state between scrambled words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= SCR_SEED;
        else if (en)
            st_q <= nxt;
    end

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 7'h00); // R7

endmodule

// File: rtl/sts_tx_formatter.sv
// STS-48 transmit frame formatter, top level.
// Interleaves 36 overhead words with 1044 payload words in each of 9 rows.
// Latches the mode and the scrambler bypass on the frame-start word.
// Scrambles everything after row 0's overhead; the output is registered once.
module sts_tx_formatter #(
    parameter int W = 32,
    parameter int ROWS = 9,
    parameter int WORDS_PER_ROW = 1080,
    parameter int OH_WORDS = 36,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(WORDS_PER_ROW)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_start,
    input  logic [1:0]   cfg_mode,
    input  logic         cfg_scr_off,
    input  logic [W-1:0] oh_in,
    input  logic [W-1:0] pl_in,
    output logic [W-1:0] tx_data,
    output logic         tx_oh,
    output logic         tx_sof,
    output logic         tx_active
);

    logic          cur_act;
    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    logic [1:0]    mode_q, mode_eff;
    logic          off_q, off_eff;
    logic          is_oh, row0_oh, seed, scr_en;
    logic [W-1:0]  oh_word, ks, word, out_word;

    sts_fmt_pos #(.ROWS(ROWS), .COLS(WORDS_PER_ROW)) u_pos (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cur_act(cur_act), .cur_row(cur_row), .cur_col(cur_col)
    );

    // Latch the configuration on the frame-start word only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            off_q  <= 1'b0;
        end else if (frame_start) begin
            mode_q <= cfg_mode;
            off_q  <= cfg_scr_off;
        end
    end

    // The frame-start word already uses the new configuration.
    always_comb begin
        mode_eff = frame_start ? cfg_mode : mode_q;
        off_eff  = frame_start ? cfg_scr_off : off_q;
        is_oh    = cur_col < CW'(OH_WORDS);
        row0_oh  = is_oh && (cur_row == '0);
        seed     = cur_act && (cur_row == '0) && (cur_col == CW'(OH_WORDS));
        scr_en   = cur_act && !row0_oh;
    end

    sts_fmt_ohsel #(.W(W), .OH_WORDS(OH_WORDS), .CW(CW)) u_ohsel (
        .mode(mode_eff), .row_is0(cur_row == '0), .col(cur_col),
        .oh_in(oh_in), .oh_word(oh_word)
    );

    sts_fmt_scr #(.W(W)) u_scr (
        .clk(clk), .rst_n(rst_n), .seed(seed), .en(scr_en), .ks(ks)
    );

    // Merge overhead and payload, then apply the keystream when enabled.
    always_comb begin
        word     = is_oh ? oh_word : pl_in;
        out_word = (scr_en && !off_eff) ? (word ^ ks) : word;
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data   <= '0;
            tx_oh     <= 1'b0;
            tx_sof    <= 1'b0;
            tx_active <= 1'b0;
        end else begin
            tx_data   <= cur_act ? out_word : '0;
            tx_oh     <= cur_act && is_oh;
            tx_sof    <= frame_start;
            tx_active <= cur_act;
        end
    end

    AST_SOF_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (tx_sof && tx_oh && tx_active)); // R1
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> (tx_data == '0 && !tx_oh && !tx_sof)); // R3
    AST_ROW0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_act && row0_oh) |=> (tx_data == $past(oh_word))); // R7
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_act && off_eff && !is_oh) |=> (tx_data == $past(pl_in))); // R8
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(mode_q) && $stable(off_q))); // R9

endmodule

// File: tb/sts_tx_formatter_tb.sv
// Self-checking bench: word-by-word model of position, overhead source and scrambler.
module sts_tx_formatter_tb;

    localparam int ROWS = 9;
    localparam int COLS = 1080;
    localparam int OHW  = 36;
    localparam int FRAME = ROWS * COLS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_scr_off = 1'b0;
    logic [31:0] oh_in = '0;
    logic [31:0] pl_in = '0;
    logic [31:0] tx_data;
    logic        tx_oh, tx_sof, tx_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit       m_act = 0;
    int       m_row = 0, m_col = 0;
    bit [1:0] m_mode = 0;
    bit       m_off = 0;
    bit [6:0] m_scr = 7'h7F;
    int       oh_seen, act_seen;

    always #5 clk = ~clk;

    sts_tx_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_mode(cfg_mode), .cfg_scr_off(cfg_scr_off),
        .oh_in(oh_in), .pl_in(pl_in),
        .tx_data(tx_data), .tx_oh(tx_oh), .tx_sof(tx_sof), .tx_active(tx_active)
    );

    // Expected overhead word per R4, R5, R6.
    function automatic logic [31:0] exp_oh(input bit [1:0] md, input int row, input int col,
                                           input logic [31:0] din);
        if (md == 2'd0) return din;
        if (row == 0 && col < 12) return 32'hF6F6F6F6;
        if (row == 0 && col < 24) return 32'h28282828;
        if (md == 2'd1 || row == 0) return din;
        return 32'h0;
    endfunction

    // Keystream per R7: 32 generator steps, first bit at bit 31.
    function automatic logic [31:0] keystream(input bit [6:0] r0, output bit [6:0] r1);
        logic [31:0] k = '0;
        bit [6:0] r = r0;
        for (int b = 31; b >= 0; b--) begin
            bit fb;
            k[b] = r[6];
            fb = r[6] ^ r[5];
            r = {r[5:0], fb};
        end
        r1 = r;
        return k;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One word: drive inputs, predict, then sample after the edge (R11: one stage).
    task automatic step(input bit fs, input bit [1:0] md, input bit off);
        logic [31:0] e_data;
        bit e_oh, e_act, row0oh;
        string tag;
        @(negedge clk);
        frame_start = fs;
        cfg_mode    = md;
        cfg_scr_off = off;
        oh_in       = $urandom;
        pl_in       = $urandom;
        if (fs) begin
            m_act = 1; m_row = 0; m_col = 0; m_mode = md; m_off = off;
        end
        e_data = '0; e_oh = 0; e_act = m_act; tag = "R3";
        if (m_act) begin
            e_oh   = (m_col < OHW);
            row0oh = e_oh && (m_row == 0);
            if (e_oh) begin
                e_data = exp_oh(m_mode, m_row, m_col, oh_in);
                tag = (m_mode == 0) ? "R4" : (m_mode == 1) ? "R5" : "R6";
            end else begin
                e_data = pl_in;
                tag = "R2";
            end
            if (m_row == 0 && m_col == OHW) m_scr = 7'h7F;
            if (!row0oh) begin
                bit [6:0] nx;
                logic [31:0] k = keystream(m_scr, nx);
                m_scr = nx;
                if (!m_off) e_data ^= k;
            end
            tag = {tag, m_off ? "/R8/R9" : "/R7/R9"};
            if (m_col == COLS - 1) begin
                m_col = 0;
                if (m_row == ROWS - 1) begin m_act = 0; m_row = 0; end
                else m_row++;
            end else m_col++;
        end
        @(posedge clk);
        #1;
        check({tag, " data"}, tx_data, e_data);
        check("R2 oh flag", {31'b0, tx_oh}, {31'b0, e_oh});
        check(fs ? "R1 sof" : "R10 sof", {31'b0, tx_sof}, {31'b0, fs});
        check("R3 active", {31'b0, tx_active}, {31'b0, e_act});
        oh_seen  += tx_oh;
        act_seen += tx_active;
    endtask

    // A frame of 'len' words; cfg is redrawn at random after the first word (R9).
    task automatic run_frame(input bit [1:0] md, input bit off, input int len);
        oh_seen = 0; act_seen = 0;
        step(1'b1, md, off);
        for (int i = 1; i < len; i++) step(1'b0, 2'($urandom), 1'($urandom));
        if (len == FRAME) begin
            check("R2 oh words per frame", 32'(oh_seen), 32'(ROWS * OHW));
            check("R3 words per frame", 32'(act_seen), 32'(FRAME));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'($urandom), 1'($urandom));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // reset state (R3)
        check("R3 reset data", tx_data, 32'h0);
        check("R3 reset active", {31'b0, tx_active}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(10);                         // R3: idle before any pulse
        run_frame(2'd0, 1'b0, FRAME);     // R4, R7
        idle(5);
        run_frame(2'd1, 1'b0, FRAME);     // R5
        idle(5);
        run_frame(2'd2, 1'b1, FRAME);     // R6, R8
        run_frame(2'd3, 1'b0, 3000);      // R10: cut short mid-row
        run_frame(2'd0, 1'b1, 40);        // R10: cut again right after the seed word
        run_frame(2'd3, 1'b0, FRAME);     // R6, R7, R10 recovery
        idle(20);                         // R3: back to idle
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule